// File: doc/BRIEF.md
# Burst Word Mover with Replicate Mode

This block moves a run of 32-bit words between a small local register file and a larger shared memory. Both memories sit outside the block and are reached through simple read and write ports. Each read returns its data one clock after the request. A transfer takes two commands. A setup command first loads a 32-bit count register. The next move command takes its word count from that register. After that the register falls back to a value that moves one word.

There are two directions: shared memory into the register file, and the register file out to shared memory. Setting the top bit of the count turns the copy into a replicate operation. The engine then fetches only the first source word and writes that one value to every destination address in the run. A third move command does the same replication from one local register across a run of local registers.

Shared memory is served by a rotating slot arbiter, modelled here as a slot-phase input. A move that touches shared memory waits for the slot whose phase matches the low bits of its shared address. Once started, the engine reads and writes one word per clock. A busy flag covers the whole transfer and a one-clock done pulse ends it.

Top module: `blkx_xfer_engine`

## Requirements
- R1: Command codes on `cmd_op` are 0 setup, 1 load (shared to local), 2 store (local to shared) and 3 local replicate. A setup stores `cmd_arg` as the count, and the next move command transfers `count[30:0]` words.
- R2: A load with count bit 31 clear copies shared word S+i into local register D+i for each i below the count, with both addresses advancing by one per word.
- R3: A store with count bit 31 clear copies local register L+i into shared word A+i for each i below the count.
- R4: A load or store with count bit 31 set issues exactly one source read and writes that value to every destination address of the run.
- R5: Once the first destination write appears, the writes of one transfer come out on consecutive clocks, so N words take N write cycles.
- R6: For loads and stores, the first source read is issued on the clock edge at which `slot_phase` equals the low 3 bits of the shared address given with the command.
- R7: Command 3 reads local register `cmd_arg[5:0]` once and writes its value to local registers D, D+1, … for the programmed count, whatever the state of count bit 31.
- R8: A count of 0 writes nothing, keeps `busy` low, and raises `done` in the cycle right after the command.
- R9: Each move command consumes the setup value. A later move command with no new setup moves exactly one word.
- R10: `busy` rises in the cycle after an accepted move command and stays high through the cycle of the last write. `done` is high for exactly one cycle, the cycle after the last write, and `busy` is low in that cycle.
- R11: Any command, setup included, that arrives while `busy` is high is ignored. It changes neither the transfer in progress nor the count register.
- R12: Local addresses wrap modulo the 64-entry register file, and shared addresses wrap modulo the 1024-word memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | Command code (0 setup, 1 load, 2 store, 3 local replicate) |
| cmd_arg | input | 32 | Count value for setup; source register for local replicate |
| cmd_shm_addr | input | 10 | Shared-memory start address |
| cmd_loc_addr | input | 6 | Local register start address |
| slot_phase | input | 3 | Current phase of the rotating shared-memory slot |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| shm_rd_en | output | 1 | Shared-memory read request |
| shm_rd_addr | output | 10 | Shared-memory read address |
| shm_rd_data | input | 32 | Shared-memory read data, one cycle after request |
| shm_wr_en | output | 1 | Shared-memory write strobe |
| shm_wr_addr | output | 10 | Shared-memory write address |
| shm_wr_data | output | 32 | Shared-memory write data |
| loc_rd_en | output | 1 | Local register read request |
| loc_rd_addr | output | 6 | Local register read address |
| loc_rd_data | input | 32 | Local register read data, one cycle after request |
| loc_wr_en | output | 1 | Local register write strobe |
| loc_wr_addr | output | 6 | Local register write address |
| loc_wr_data | output | 32 | Local register write data |

## Verification
The bench builds the block with its default parameters: a 1024-word shared memory, a 64-entry register file and an 8-phase slot rotation. At these sizes a short run can start near the top of either memory and cross both wrap points. The slot wait is at most seven cycles, and every one of the eight phase alignments can be reached with a few start addresses. A 16-word burst fits many times over in a short run, which lets the bench compare write-to-write spacing and the single fetch of replicate mode against the count.

// File: rtl/blkx_pkg.sv
package blkx_pkg;
  typedef enum logic [1:0] {
    OP_SETUP = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_LFILL = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_LAST = 2'd3
  } st_e;
endpackage

// File: rtl/blkx_count_reg.sv
module blkx_count_reg #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  input  logic          consume,
  output logic [CW-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= CW'(1);
    else if (load_en) cnt_q <= load_val;
    else if (consume) cnt_q <= CW'(1);
  end
endmodule

// File: rtl/blkx_seq.sv
module blkx_seq
  import blkx_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 10,
  parameter int SB = 3,
  parameter int CW = 32,
  localparam int LW = CW - 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          start_fill,
  input  logic [LW-1:0] start_len,
  input  logic [AW-1:0] start_src,
  input  logic [AW-1:0] start_dst,
  input  logic          need_slot,
  input  logic [SB-1:0] start_slot,
  input  logic [SB-1:0] slot_phase,
  input  logic [DW-1:0] rd_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          done
);
  st_e           state;
  logic [LW-1:0] rd_left, wr_left;
  logic [AW-1:0] src_ptr, dst_ptr;
  logic [SB-1:0] slot_q;
  logic          fill_q, rdv, have_hold;
  logic [DW-1:0] hold;
  logic          rd_go, wr_go;

  always_comb begin
    rd_go = ((state == ST_WAIT) && (slot_phase == slot_q)) ||
            ((state == ST_RUN) && (rd_left != '0));
    wr_go = (wr_left != '0) && (rdv || (fill_q && have_hold));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      rd_req    <= 1'b0;
      wr_req    <= 1'b0;
      rdv       <= 1'b0;
      have_hold <= 1'b0;
      fill_q    <= 1'b0;
      rd_left   <= '0;
      wr_left   <= '0;
      src_ptr   <= '0;
      dst_ptr   <= '0;
      slot_q    <= '0;
      hold      <= '0;
      rd_addr   <= '0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      done   <= 1'b0;
      rd_req <= 1'b0;
      wr_req <= 1'b0;
      rdv    <= rd_req;
      if (rdv && fill_q) begin
        hold      <= rd_data;
        have_hold <= 1'b1;
      end
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (start_len == '0) begin
              done <= 1'b1;
            end else begin
              busy      <= 1'b1;
              state     <= need_slot ? ST_WAIT : ST_RUN;
              rd_left   <= start_len;
              wr_left   <= start_len;
              src_ptr   <= start_src;
              dst_ptr   <= start_dst;
              fill_q    <= start_fill;
              have_hold <= 1'b0;
              slot_q    <= start_slot;
            end
          end
        end
        ST_LAST: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
          done  <= 1'b1;
        end
        default: ;
      endcase
      if (rd_go) begin
        rd_req  <= 1'b1;
        rd_addr <= src_ptr;
        src_ptr <= src_ptr + 1'b1;
        rd_left <= fill_q ? '0 : rd_left - 1'b1;
        state   <= ST_RUN;
      end
      if (wr_go) begin
        wr_req  <= 1'b1;
        wr_addr <= dst_ptr;
        dst_ptr <= dst_ptr + 1'b1;
        wr_data <= rdv ? rd_data : hold;
        wr_left <= wr_left - 1'b1;
        if (wr_left == LW'(1)) state <= ST_LAST;
      end
    end
  end
endmodule

// File: rtl/blkx_xfer_engine.sv
module blkx_xfer_engine
  import blkx_pkg::*;
#(
  parameter int DW     = 32,
  parameter int CW     = 32,
  parameter int SHM_AW = 10,
  parameter int LOC_AW = 6,
  parameter int SB     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [CW-1:0]     cmd_arg,
  input  logic [SHM_AW-1:0] cmd_shm_addr,
  input  logic [LOC_AW-1:0] cmd_loc_addr,
  input  logic [SB-1:0]     slot_phase,
  output logic              busy,
  output logic              done,
  output logic              shm_rd_en,
  output logic [SHM_AW-1:0] shm_rd_addr,
  input  logic [DW-1:0]     shm_rd_data,
  output logic              shm_wr_en,
  output logic [SHM_AW-1:0] shm_wr_addr,
  output logic [DW-1:0]     shm_wr_data,
  output logic              loc_rd_en,
  output logic [LOC_AW-1:0] loc_rd_addr,
  input  logic [DW-1:0]     loc_rd_data,
  output logic              loc_wr_en,
  output logic [LOC_AW-1:0] loc_wr_addr,
  output logic [DW-1:0]     loc_wr_data
);
  localparam int AW = SHM_AW;

  op_e           op_in, op_q;
  logic          setup_go, xfer_go;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] src_sel, dst_sel, rd_addr, wr_addr;
  logic [DW-1:0] rd_data_sel, wr_data;
  logic          rd_req, wr_req;

  assign op_in    = op_e'(cmd_op);
  assign setup_go = cmd_valid && !busy && (op_in == OP_SETUP);
  assign xfer_go  = cmd_valid && !busy && (op_in != OP_SETUP);

  blkx_count_reg #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .load_en(setup_go), .load_val(cmd_arg),
    .consume(xfer_go), .cnt_q(cnt_q)
  );

  always_comb begin
    case (op_in)
      OP_LOAD: begin
        src_sel = cmd_shm_addr;
        dst_sel = AW'(cmd_loc_addr);
      end
      OP_STORE: begin
        src_sel = AW'(cmd_loc_addr);
        dst_sel = cmd_shm_addr;
      end
      default: begin
        src_sel = AW'(cmd_arg[LOC_AW-1:0]);
        dst_sel = AW'(cmd_loc_addr);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          op_q <= OP_LOAD;
    else if (xfer_go) op_q <= op_in;
  end

  assign rd_data_sel = (op_q == OP_LOAD) ? shm_rd_data : loc_rd_data;

  blkx_seq #(.DW(DW), .AW(AW), .SB(SB), .CW(CW)) u_seq (
    .clk(clk), .rst(rst), .start(xfer_go),
    .start_fill(cnt_q[CW-1] || (op_in == OP_LFILL)),
    .start_len(cnt_q[CW-2:0]), .start_src(src_sel), .start_dst(dst_sel),
    .need_slot(op_in != OP_LFILL), .start_slot(cmd_shm_addr[SB-1:0]),
    .slot_phase(slot_phase), .rd_data(rd_data_sel),
    .rd_req(rd_req), .rd_addr(rd_addr), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .done(done)
  );

  assign shm_rd_en   = rd_req && (op_q == OP_LOAD);
  assign shm_rd_addr = rd_addr;
  assign loc_rd_en   = rd_req && (op_q != OP_LOAD);
  assign loc_rd_addr = rd_addr[LOC_AW-1:0];
  assign shm_wr_en   = wr_req && (op_q == OP_STORE);
  assign shm_wr_addr = wr_addr;
  assign shm_wr_data = wr_data;
  assign loc_wr_en   = wr_req && (op_q != OP_STORE);
  assign loc_wr_addr = wr_addr[LOC_AW-1:0];
  assign loc_wr_data = wr_data;
endmodule

// File: rtl/blkx_xfer_chk.sv
module blkx_xfer_chk #(
  parameter int SHM_AW = 10,
  parameter int LOC_AW = 6,
  parameter int SB     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              busy,
  input logic              done,
  input logic [SB-1:0]     slot_phase,
  input logic              shm_rd_en,
  input logic [SHM_AW-1:0] shm_rd_addr,
  input logic              shm_wr_en,
  input logic [SHM_AW-1:0] shm_wr_addr,
  input logic              loc_wr_en,
  input logic [LOC_AW-1:0] loc_wr_addr
);
  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10
  write_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (shm_wr_en || loc_wr_en) |-> busy);
  // R10
  busy_after_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid));
  // R6
  slot_start_chk: assert property (@(posedge clk) disable iff (rst)
    (shm_rd_en && !$past(shm_rd_en)) |-> ($past(slot_phase) == shm_rd_addr[SB-1:0]));
  // R12
  shm_step_chk: assert property (@(posedge clk) disable iff (rst)
    (shm_wr_en && $past(shm_wr_en)) |-> (shm_wr_addr == SHM_AW'($past(shm_wr_addr) + 1'b1)));
  // R12
  loc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (loc_wr_en && $past(loc_wr_en)) |-> (loc_wr_addr == LOC_AW'($past(loc_wr_addr) + 1'b1)));
endmodule

bind blkx_xfer_engine blkx_xfer_chk #(.SHM_AW(SHM_AW), .LOC_AW(LOC_AW), .SB(SB)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .slot_phase(slot_phase), .shm_rd_en(shm_rd_en), .shm_rd_addr(shm_rd_addr),
  .shm_wr_en(shm_wr_en), .shm_wr_addr(shm_wr_addr),
  .loc_wr_en(loc_wr_en), .loc_wr_addr(loc_wr_addr)
);

// File: tb/blkx_xfer_engine_tb_top.sv
`timescale 1ns/1ps
module blkx_xfer_engine_tb_top;
  localparam int SHM_N = 1024;
  localparam int LOC_N = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [31:0] cmd_arg = '0;
  logic [9:0]  cmd_shm_addr = '0;
  logic [5:0]  cmd_loc_addr = '0;
  logic [2:0]  slot = '0;
  logic        busy, done;
  logic        shm_rd_en, shm_wr_en, loc_rd_en, loc_wr_en;
  logic [9:0]  shm_rd_addr, shm_wr_addr;
  logic [5:0]  loc_rd_addr, loc_wr_addr;
  logic [31:0] shm_rd_data = '0, loc_rd_data = '0, shm_wr_data, loc_wr_data;

  logic [31:0] shm_mem [SHM_N];
  logic [31:0] loc_mem [LOC_N];

  blkx_xfer_engine dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .cmd_shm_addr(cmd_shm_addr), .cmd_loc_addr(cmd_loc_addr), .slot_phase(slot),
    .busy(busy), .done(done),
    .shm_rd_en(shm_rd_en), .shm_rd_addr(shm_rd_addr), .shm_rd_data(shm_rd_data),
    .shm_wr_en(shm_wr_en), .shm_wr_addr(shm_wr_addr), .shm_wr_data(shm_wr_data),
    .loc_rd_en(loc_rd_en), .loc_rd_addr(loc_rd_addr), .loc_rd_data(loc_rd_data),
    .loc_wr_en(loc_wr_en), .loc_wr_addr(loc_wr_addr), .loc_wr_data(loc_wr_data)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    slot <= rst ? 3'd0 : slot + 3'd1;
    if (shm_rd_en) shm_rd_data <= shm_mem[shm_rd_addr];
    if (shm_wr_en) shm_mem[shm_wr_addr] <= shm_wr_data;
    if (loc_rd_en) loc_rd_data <= loc_mem[loc_rd_addr];
    if (loc_wr_en) loc_mem[loc_wr_addr] <= loc_wr_data;
  end

  typedef struct { bit to_shm; int addr; logic [31:0] data; } item_t;
  item_t sbq[$];

  int    nchecks = 0, nerr = 0, cyc = 0;
  int    nwr = 0, nrd = 0, first_wr = 0, last_wr = 0;
  bit    busy_seen = 0, slot_chk = 0;
  logic [2:0] exp_slot = '0;
  string cur_req = "R1";

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    logic [2:0] prev_slot;
    cyc++;
    if (!rst) begin
      if (busy) busy_seen = 1;
      if ((shm_rd_en || loc_rd_en) && nrd == 0 && slot_chk) begin
        prev_slot = slot - 3'd1;
        check(prev_slot == exp_slot, "R6", "slot at first read", prev_slot, exp_slot);
      end
      if (shm_rd_en || loc_rd_en) nrd++;
      if (shm_wr_en || loc_wr_en) begin
        if (sbq.size() == 0) begin
          check(0, cur_req, "unexpected write", shm_wr_en ? shm_wr_addr : loc_wr_addr, 0);
        end else begin
          item_t it;
          int    wa;
          logic [31:0] wd;
          it = sbq.pop_front();
          wa = shm_wr_en ? int'(shm_wr_addr) : int'(loc_wr_addr);
          wd = shm_wr_en ? shm_wr_data : loc_wr_data;
          check(shm_wr_en == it.to_shm && !(shm_wr_en && loc_wr_en), cur_req, "write target",
                shm_wr_en, it.to_shm);
          check(wa == it.addr, cur_req, "write address", wa, it.addr);
          check(wd == it.data, cur_req, "write data", wd, it.data);
        end
        if (nwr == 0) first_wr = cyc;
        last_wr = cyc;
        nwr++;
      end
    end
  end

  // driver: compute expected writes from the requirements
  task automatic push_exp(int op, int n, bit fill, int shm_a, int loc_a, int src_l, string req);
    cur_req = req; nwr = 0; nrd = 0; busy_seen = 0;
    slot_chk = (op != 3); exp_slot = shm_a[2:0];
    for (int i = 0; i < n; i++) begin
      item_t it;
      int k;
      k = fill ? 0 : i;
      case (op)
        1: begin it.to_shm = 0; it.addr = (loc_a + i) % LOC_N; it.data = shm_mem[(shm_a + k) % SHM_N]; end
        2: begin it.to_shm = 1; it.addr = (shm_a + i) % SHM_N; it.data = loc_mem[(loc_a + k) % LOC_N]; end
        default: begin it.to_shm = 0; it.addr = (loc_a + i) % LOC_N; it.data = loc_mem[src_l]; end
      endcase
      sbq.push_back(it);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [31:0] arg, int shm_a, int loc_a);
    @(negedge clk); #1;
    cmd_valid = 1; cmd_op = op; cmd_arg = arg;
    cmd_shm_addr = 10'(shm_a); cmd_loc_addr = 6'(loc_a);
    @(negedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic finish_xfer(int n, bit fill, string req);
    int t = 0;
    while (!done && t < 3000) begin @(negedge clk); #1; t++; end
    check(done, req, "done seen", done, 1);
    if (n > 0) begin
      check(cyc - 1 == last_wr, "R10", "done right after last write", cyc - 1, last_wr);
      check(last_wr - first_wr == n - 1, "R5", "write span", last_wr - first_wr, n - 1);
    end
    check(busy == 0, "R10", "busy low with done", busy, 0);
    check(nwr == n, req, "write count", nwr, n);
    check(nrd == (n == 0 ? 0 : (fill ? 1 : n)), fill ? "R4" : req, "read count", nrd,
          n == 0 ? 0 : (fill ? 1 : n));
    check(busy_seen == (n > 0), "R10", "busy seen", busy_seen, n > 0);
    check(sbq.size() == 0, req, "scoreboard drained", sbq.size(), 0);
    @(negedge clk); #1;
    check(done == 0, "R10", "done one cycle", done, 0);
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic xfer(int op, logic [31:0] cnt, int shm_a, int loc_a, int src_l, string req);
    int n;
    bit fill;
    n = int'(cnt[30:0]);
    fill = cnt[31] || (op == 3);
    push_exp(op, n, fill, shm_a, loc_a, src_l, req);
    issue(2'd0, cnt, 0, 0);
    issue(2'(op), 32'(src_l), shm_a, loc_a);
    finish_xfer(n, fill, req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nerr++; nchecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < SHM_N; i++) shm_mem[i] = 32'hA5000000 ^ (i * 32'h00010203);
    for (int i = 0; i < LOC_N; i++) loc_mem[i] = 32'h10000000 + i * 32'h00000107;
    repeat (4) @(negedge clk);
    #1;
    check(busy == 0 && done == 0, "R10", "reset outputs", {busy, done}, 0);
    check(!shm_rd_en && !shm_wr_en && !loc_rd_en && !loc_wr_en, "R10", "reset strobes",
          {shm_rd_en, shm_wr_en, loc_rd_en, loc_wr_en}, 0);
    rst = 0;
    repeat (2) @(negedge clk);
    #1;
    // R1 R2: 16-word load copy
    xfer(1, 32'd16, 10'h013, 4, 0, "R2");
    // R3 R12: store copy crossing both wrap points
    xfer(2, 32'd4, 10'h3FE, 62, 0, "R12");
    // R3: plain store copy, other slot alignment
    xfer(2, 32'd9, 10'h105, 10, 0, "R3");
    // R4: store replicate across shared wrap
    xfer(2, 32'h8000000A, 10'h3FC, 7, 0, "R4");
    // R4: load replicate
    xfer(1, 32'h80000005, 10'h02F, 50, 0, "R4");
    // R7: local replicate, bit 31 clear
    xfer(3, 32'd6, 0, 40, 3, "R7");
    // R8: count zero
    push_exp(1, 0, 0, 10'h011, 0, 0, "R8");
    issue(2'd0, 32'd0, 0, 0);
    issue(2'd1, 32'd0, 10'h011, 0);
    check(done == 1, "R8", "done cycle after command", done, 1);
    finish_xfer(0, 0, "R8");
    // R11: commands during busy ignored
    push_exp(1, 12, 0, 10'h040, 20, 0, "R11");
    issue(2'd0, 32'd12, 0, 0);
    issue(2'd1, 32'd0, 10'h040, 20);
    repeat (6) @(negedge clk);
    #1;
    check(busy == 1, "R10", "busy during burst", busy, 1);
    issue(2'd0, 32'd50, 0, 0);
    issue(2'd1, 32'd0, 10'h080, 30);
    finish_xfer(12, 0, "R11");
    // R9: no new setup moves one word (the ignored setup left nothing behind)
    push_exp(1, 1, 0, 10'h055, 50, 0, "R9");
    issue(2'd1, 32'd0, 10'h055, 50);
    finish_xfer(1, 0, "R9");
    // R1: count register reloaded for a store
    xfer(2, 32'd3, 10'h200, 0, 0, "R1");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule